// File: doc/BRIEF.md
# Video Processor CPU Register Interface

This block is the register file a CPU sees when it talks to a tile-based video processor. The CPU reaches eight byte-wide registers through an 8-bit data bus, a register address, and read and write strobes. Only the low three address bits choose the register, so the eight registers repeat across the whole CPU window. The registers cover control, mask, status, a sprite-memory pointer and data port, scroll, a video-memory address, and a video-memory data port.

The scroll register and the video address register each take two writes. They share one first/second toggle. Reading status clears that toggle and the vblank flag. The video address is 14 bits wide. It steps by 1 or by 32 after every data-port access and wraps at 14 bits. Video-memory reads pass through a one-byte read buffer. The sprite attribute memory sits inside the block, behind its own pointer.

Top module: `vp_reg_if`

## Requirements
- R1: The register is chosen by `addr_i[2:0]` only: 0 control, 1 mask, 2 status, 3 sprite pointer, 4 sprite data, 5 scroll, 6 video address, 7 video data. The upper address bits are ignored.
- R2: A control write is shown on `ctrl_o`. In this byte, bit 7 is interrupt enable, bit 2 is increment mode, and bits 1:0 are nametable select. `nmi_o` is high when control bit 7 and the vblank flag are both set.
- R3: A mask write is shown unchanged on `mask_o`.
- R4: A status read returns {vblank, sprite-zero hit, sprite overflow, 5'b0}. The read clears vblank after the cycle. A `vblank_start_i` pulse sets vblank, and this set wins over a clear in the same cycle. `vblank_end_i` clears vblank.
- R5: A status read resets the shared write toggle to the first-write state.
- R6: Scroll writes alternate: the first write loads `scroll_x_o` and the second write loads `scroll_y_o`.
- R7: Video address writes alternate. The first write loads the high 6 bits from `wdata_i[5:0]`. The second write loads the low byte, and the full 14-bit address then appears on `vm_addr_o`.
- R8: A video data write drives `vm_we_o` with `vm_addr_o` and `vm_wdata_o` in the same cycle. The address then advances by 1, or by 32 when control bit 2 is set.
- R9: A video data read returns the buffered byte from the previous read. The buffer then loads `vm_rdata_i`, and the address advances as in R8. `vm_re_o` and `vm_we_o` are never high together. A write takes precedence when both strobes are set.
- R10: The video address wraps modulo 2^14.
- R11: The sprite pointer is loaded by writing register 3. A sprite data write stores the byte at the pointer and then increments the pointer, wrapping at the memory size. A sprite data read returns the byte at the pointer and leaves the pointer unchanged.
- R12: Reads of the write-only registers (0, 1, 3, 5 and 6) return 0. `rdata_o` is 0 when no read is in progress.
- R13: After reset, control, mask, scroll, video address, the read buffer, the toggle, vblank and the sprite pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | BUS_AW | CPU address within the decoded window |
| wr_i | input | 1 | CPU write strobe |
| rd_i | input | 1 | CPU read strobe |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | CPU read data |
| vblank_start_i | input | 1 | Pulse that sets the vblank flag |
| vblank_end_i | input | 1 | Pulse that clears the vblank flag |
| spr0_hit_i | input | 1 | Sprite-zero hit flag from the renderer |
| spr_ovf_i | input | 1 | Sprite overflow flag from the renderer |
| vm_addr_o | output | VA_W | Video memory address |
| vm_wdata_o | output | 8 | Video memory write data |
| vm_we_o | output | 1 | Video memory write strobe |
| vm_re_o | output | 1 | Video memory read strobe |
| vm_rdata_i | input | 8 | Video memory read data, valid in the same cycle |
| ctrl_o | output | 8 | Control register |
| mask_o | output | 8 | Mask register |
| scroll_x_o | output | 8 | Horizontal scroll |
| scroll_y_o | output | 8 | Vertical scroll |
| vblank_o | output | 1 | Vblank flag |
| nmi_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 13-bit CPU window, a 14-bit video address and a 256-entry sprite memory. With these values, mirrored accesses through high addresses such as 0x1FF8 are in range. Both 14-bit wrap paths can be reached from top-of-range addresses: 0x3FFF plus 1, and 0x3FF0 plus 32. The sprite pointer can be taken from 255 back to 0 with a single write. The video memory is modelled as a computed function of the address, so every byte in the read-buffer sequence has a known value.

// File: rtl/vp_regs_pkg.sv
package vp_regs_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_MASK = 3'd1,
    REG_STAT = 3'd2,
    REG_SPTR = 3'd3,
    REG_SDAT = 3'd4,
    REG_SCRL = 3'd5,
    REG_VADR = 3'd6,
    REG_VDAT = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned DW       = 8;
  localparam int unsigned NMI_BIT  = 7;
  localparam int unsigned INC_BIT  = 2;
  localparam int unsigned ROW_STEP = 32;
endpackage

// File: rtl/vp_ctrl_regs.sv
module vp_ctrl_regs
  import vp_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctrl_i,
  input  logic          wr_mask_i,
  input  logic          rd_stat_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          vbl_set_i,
  input  logic          vbl_clr_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] mask_o,
  output logic          vblank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      mask_o   <= '0;
      vblank_o <= 1'b0;
    end else begin
      if (wr_ctrl_i) ctrl_o <= wdata_i;
      if (wr_mask_i) mask_o <= wdata_i;
      // set wins over any clear in the same cycle
      if (vbl_set_i)                  vblank_o <= 1'b1;
      else if (vbl_clr_i | rd_stat_i) vblank_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vp_vaddr_unit.sv
module vp_vaddr_unit
  import vp_regs_pkg::*;
#(
  parameter int unsigned VA_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_scrl_i,
  input  logic            wr_vadr_i,
  input  logic            wr_vdat_i,
  input  logic            rd_vdat_i,
  input  logic            rd_stat_i,
  input  logic            inc32_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   vm_rdata_i,
  output logic [DW-1:0]   scroll_x_o,
  output logic [DW-1:0]   scroll_y_o,
  output logic [VA_W-1:0] vaddr_o,
  output logic [DW-1:0]   rbuf_o
);
  localparam int unsigned HI_W = VA_W - DW;

  logic            toggle_q;
  logic [HI_W-1:0] hi_q;
  logic [VA_W-1:0] step;

  assign step = inc32_i ? VA_W'(ROW_STEP) : VA_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toggle_q   <= 1'b0;
      hi_q       <= '0;
      scroll_x_o <= '0;
      scroll_y_o <= '0;
      vaddr_o    <= '0;
      rbuf_o     <= '0;
    end else begin
      if (rd_stat_i) toggle_q <= 1'b0;
      if (wr_scrl_i) begin
        toggle_q <= ~toggle_q;
        if (!toggle_q) scroll_x_o <= wdata_i;
        else           scroll_y_o <= wdata_i;
      end
      if (wr_vadr_i) begin
        toggle_q <= ~toggle_q;
        if (!toggle_q) hi_q    <= wdata_i[HI_W-1:0];
        else           vaddr_o <= {hi_q, wdata_i};
      end
      if (wr_vdat_i || rd_vdat_i) vaddr_o <= vaddr_o + step;
      if (rd_vdat_i) rbuf_o <= vm_rdata_i;
    end
  end
endmodule

// File: rtl/vp_spr_port.sv
module vp_spr_port
  import vp_regs_pkg::*;
#(
  parameter int unsigned SPR_AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ptr_i,
  input  logic          wr_dat_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << SPR_AW;

  logic [SPR_AW-1:0] ptr_q;
  logic [DW-1:0]     mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_ptr_i) begin
      ptr_q <= wdata_i[SPR_AW-1:0];
    end else if (wr_dat_i) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_dat_i) mem_q[ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[ptr_q];
endmodule

// File: rtl/vp_reg_if.sv
module vp_reg_if
  import vp_regs_pkg::*;
#(
  parameter int unsigned BUS_AW = 13,
  parameter int unsigned VA_W   = 14,
  parameter int unsigned SPR_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              vblank_start_i,
  input  logic              vblank_end_i,
  input  logic              spr0_hit_i,
  input  logic              spr_ovf_i,
  output logic [VA_W-1:0]   vm_addr_o,
  output logic [7:0]        vm_wdata_o,
  output logic              vm_we_o,
  output logic              vm_re_o,
  input  logic [7:0]        vm_rdata_i,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        mask_o,
  output logic [7:0]        scroll_x_o,
  output logic [7:0]        scroll_y_o,
  output logic              vblank_o,
  output logic              nmi_o
);
  reg_sel_e              sel;
  logic                  rd_eff;
  logic [NUM_REGS-1:0]   wr_hit;
  logic [NUM_REGS-1:0]   rd_hit;
  logic [DW-1:0]         spr_rdata;
  logic [DW-1:0]         rbuf;

  assign sel    = reg_sel_e'(addr_i[2:0]);
  assign rd_eff = rd_i & ~wr_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign wr_hit[g] = wr_i   && (addr_i[2:0] == 3'(g));
    assign rd_hit[g] = rd_eff && (addr_i[2:0] == 3'(g));
  end

  vp_ctrl_regs u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_hit[REG_CTRL]),
    .wr_mask_i (wr_hit[REG_MASK]),
    .rd_stat_i (rd_hit[REG_STAT]),
    .wdata_i   (wdata_i),
    .vbl_set_i (vblank_start_i),
    .vbl_clr_i (vblank_end_i),
    .ctrl_o    (ctrl_o),
    .mask_o    (mask_o),
    .vblank_o  (vblank_o)
  );

  vp_vaddr_unit #(.VA_W(VA_W)) u_vaddr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_scrl_i  (wr_hit[REG_SCRL]),
    .wr_vadr_i  (wr_hit[REG_VADR]),
    .wr_vdat_i  (wr_hit[REG_VDAT]),
    .rd_vdat_i  (rd_hit[REG_VDAT]),
    .rd_stat_i  (rd_hit[REG_STAT]),
    .inc32_i    (ctrl_o[INC_BIT]),
    .wdata_i    (wdata_i),
    .vm_rdata_i (vm_rdata_i),
    .scroll_x_o (scroll_x_o),
    .scroll_y_o (scroll_y_o),
    .vaddr_o    (vm_addr_o),
    .rbuf_o     (rbuf)
  );

  vp_spr_port #(.SPR_AW(SPR_AW)) u_spr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ptr_i (wr_hit[REG_SPTR]),
    .wr_dat_i (wr_hit[REG_SDAT]),
    .wdata_i  (wdata_i),
    .rdata_o  (spr_rdata)
  );

  assign vm_we_o    = wr_hit[REG_VDAT];
  assign vm_re_o    = rd_hit[REG_VDAT];
  assign vm_wdata_o = wdata_i;
  assign nmi_o      = ctrl_o[NMI_BIT] & vblank_o;

  always_comb begin
    rdata_o = '0;
    if (rd_eff) begin
      unique case (sel)
        REG_STAT: rdata_o = {vblank_o, spr0_hit_i, spr_ovf_i, 5'b0};
        REG_SDAT: rdata_o = spr_rdata;
        REG_VDAT: rdata_o = rbuf;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vp_reg_if_chk.sv
module vp_reg_if_chk #(
  parameter int unsigned BUS_AW = 13,
  parameter int unsigned VA_W   = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_AW-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              vblank_start_i,
  input logic [VA_W-1:0]   vm_addr_o,
  input logic              vm_we_o,
  input logic              vm_re_o,
  input logic [7:0]        ctrl_o,
  input logic [7:0]        scroll_x_o,
  input logic [7:0]        scroll_y_o,
  input logic              vblank_o,
  input logic              nmi_o
);
  logic [VA_W-1:0] exp_nxt;
  logic            stat_rd;
  logic            scrl_wr;

  assign exp_nxt = vm_addr_o + (ctrl_o[2] ? VA_W'(32) : VA_W'(1));
  assign stat_rd = rd_i && !wr_i && (addr_i[2:0] == 3'd2);
  assign scrl_wr = wr_i && (addr_i[2:0] == 3'd5);

  a_r8_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vm_we_o || vm_re_o) |=> vm_addr_o == $past(exp_nxt));

  a_r4_vbl_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !vblank_start_i) |=> !vblank_o);

  a_r4_vbl_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_start_i |=> vblank_o);

  a_r2_nmi_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (ctrl_o[7] && vblank_o));

  a_r6_scroll_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scrl_wr |=> ($stable(scroll_x_o) && $stable(scroll_y_o)));

  a_r9_port_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vm_we_o && vm_re_o));
endmodule

bind vp_reg_if vp_reg_if_chk #(.BUS_AW(BUS_AW), .VA_W(VA_W)) u_chk (.*);

// File: tb/vp_reg_if_bench.sv
module vp_reg_if_bench;
  localparam int unsigned BUS_AW = 13;
  localparam int unsigned VA_W   = 14;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [BUS_AW-1:0] addr = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              vbl_start = 1'b0, vbl_end = 1'b0, spr0 = 1'b0, sovf = 1'b0;
  logic [VA_W-1:0]   vm_addr;
  logic [7:0]        vm_wdata, vm_rdata, ctrl, mask, sx, sy;
  logic              vm_we, vm_re, vblank, nmi;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] vmem(input logic [VA_W-1:0] a);
    return a[7:0] ^ {2'b00, a[13:8]};
  endfunction
  assign vm_rdata = vmem(vm_addr);

  vp_reg_if u_vp_reg_if (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .vblank_start_i(vbl_start),
    .vblank_end_i(vbl_end), .spr0_hit_i(spr0), .spr_ovf_i(sovf),
    .vm_addr_o(vm_addr), .vm_wdata_o(vm_wdata), .vm_we_o(vm_we), .vm_re_o(vm_re),
    .vm_rdata_i(vm_rdata), .ctrl_o(ctrl), .mask_o(mask), .scroll_x_o(sx),
    .scroll_y_o(sy), .vblank_o(vblank), .nmi_o(nmi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [BUS_AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [BUS_AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_vaddr(input logic [13:0] a);
    cpu_wr(13'd6, {2'b00, a[13:8]});
    cpu_wr(13'd6, a[7:0]);
  endtask

  task automatic t_reset;
    chk("R13 ctrl", ctrl, 0);   chk("R13 mask", mask, 0);
    chk("R13 vaddr", vm_addr, 0); chk("R13 scroll", {sx, sy}, 0);
    chk("R13 vblank", vblank, 0); chk("R13 nmi", nmi, 0);
  endtask

  task automatic t_ctrl_mask;
    logic [7:0] d;
    cpu_wr(13'h1FF8, 8'h84);
    chk("R1 mirrored ctrl", ctrl, 8'h84);
    cpu_wr(13'h0009, 8'h1E);
    chk("R3 mask", mask, 8'h1E);
    cpu_rd(13'h0000, d); chk("R12 ctrl reads 0", d, 0);
    cpu_rd(13'h0006, d); chk("R12 vaddr reads 0", d, 0);
  endtask

  task automatic t_status;
    logic [7:0] d;
    @(negedge clk); vbl_start = 1'b1; spr0 = 1'b1;
    @(negedge clk); vbl_start = 1'b0;
    chk("R2 nmi on", nmi, 1);
    cpu_rd(13'h0A5A, d);
    chk("R4 status byte", d, 8'hC0);
    chk("R4 vblank cleared", vblank, 0);
    chk("R2 nmi off", nmi, 0);
    spr0 = 1'b0;
    @(negedge clk); addr = 13'd2; rd = 1'b1; vbl_start = 1'b1;
    #2 chk("R4 race old value", rdata[7], 0);
    @(negedge clk); rd = 1'b0; vbl_start = 1'b0;
    chk("R4 set wins", vblank, 1);
    @(negedge clk); vbl_end = 1'b1;
    @(negedge clk); vbl_end = 1'b0;
    chk("R4 end clears", vblank, 0);
  endtask

  task automatic t_scroll;
    logic [7:0] d;
    cpu_wr(13'd5, 8'h11);
    chk("R6 x first", sx, 8'h11);
    cpu_rd(13'd2, d);
    cpu_wr(13'd5, 8'h22);
    chk("R5 toggle reset", sx, 8'h22);
    chk("R5 y untouched", sy, 0);
    cpu_wr(13'd5, 8'h33);
    chk("R6 y second", sy, 8'h33);
  endtask

  task automatic t_addr;
    cpu_wr(13'd6, 8'h21); cpu_wr(13'd6, 8'h08);
    chk("R7 vaddr", vm_addr, 14'h2108);
    cpu_wr(13'h100E, 8'hFF); cpu_wr(13'd6, 8'h00);
    chk("R7 high masked", vm_addr, 14'h3F00);
  endtask

  task automatic t_data_write;
    cpu_wr(13'd0, 8'h00);
    set_vaddr(14'h2000);
    @(negedge clk); addr = 13'd7; wdata = 8'hAB; wr = 1'b1;
    #2 chk("R8 we", vm_we, 1); chk("R8 addr", vm_addr, 14'h2000);
    chk("R8 data", vm_wdata, 8'hAB); chk("R9 no re", vm_re, 0);
    @(negedge clk); wr = 1'b0;
    chk("R8 step 1", vm_addr, 14'h2001);
    cpu_wr(13'd0, 8'h04);
    cpu_wr(13'd7, 8'hCD);
    chk("R8 step 32", vm_addr, 14'h2021);
  endtask

  task automatic t_data_read;
    logic [7:0] d;
    cpu_wr(13'd0, 8'h00);
    set_vaddr(14'h1234);
    cpu_rd(13'h0F, d);
    chk("R9 buffered first", d, 0);
    cpu_rd(13'd7, d);
    chk("R9 buffered second", d, vmem(14'h1234));
    chk("R9 addr after reads", vm_addr, 14'h1236);
  endtask

  task automatic t_wrap;
    cpu_wr(13'd0, 8'h00);
    set_vaddr(14'h3FFF);
    cpu_wr(13'd7, 8'h01);
    chk("R10 wrap +1", vm_addr, 0);
    cpu_wr(13'd0, 8'h04);
    set_vaddr(14'h3FF0);
    cpu_wr(13'd7, 8'h02);
    chk("R10 wrap +32", vm_addr, 14'h0010);
  endtask

  task automatic t_sprite;
    logic [7:0] d;
    cpu_wr(13'd3, 8'hFF);
    cpu_wr(13'd4, 8'h5A);
    cpu_wr(13'd4, 8'h6B);
    cpu_wr(13'd3, 8'hFF);
    cpu_rd(13'd4, d); chk("R11 read at ptr", d, 8'h5A);
    cpu_rd(13'd4, d); chk("R11 no inc on read", d, 8'h5A);
    cpu_wr(13'd3, 8'h00);
    cpu_rd(13'd4, d); chk("R11 ptr wrapped", d, 8'h6B);
    cpu_rd(13'd3, d); chk("R12 ptr reads 0", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_ctrl_mask;
    t_status;
    t_scroll;
    t_addr;
    t_data_write;
    t_data_read;
    t_wrap;
    t_sprite;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule